// File: doc/BRIEF.md
# Voltage/Current Conversion Sequencer

This block drives one shared 12-bit ADC that serves two channels: a supply voltage channel and a load current channel. A command write sets four mode bits. Each channel has a free-running enable and a single-shot enable. From these bits the sequencer chooses the channel to convert next and sends a start pulse with a channel select. It then waits for the converter's done handshake and stores the returned code in that channel's result holder.

A single-shot request clears itself once its conversion finishes. While any single shot is still pending, the block raises a not-ready flag, which the serial interface uses to refuse reads. When free-running conversion is enabled, a read taken before the first result sees a zero code, because enabling a channel clears that channel's stored code and its valid flag. Each new current result also gives the alert logic a one-cycle strobe. The range select is passed to the analog front end and kept alongside the voltage result.

Top module: `conv_seq`

## Requirements
- R1: After a synchronous reset, all mode bits are 0. No start pulse is issued. Both codes, both valid flags, `volt_range`, `not_ready`, both active flags and `alert_stb` are 0.
- R2: The command field `cmd_bits` has this layout: bit 0 is voltage free-running, bit 1 is voltage single-shot, bit 2 is current free-running, bit 3 is current single-shot, and bit 4 is the range. One cycle after `cmd_wr`, `volt_active` is high when bit 0 or bit 1 was written as 1, and `curr_active` is high when bit 2 or bit 3 was written as 1.
- R3: Each `adc_start` pulse lasts exactly one cycle. `adc_sel` is 0 for voltage and 1 for current. No new start is issued until `adc_done` has returned for the previous start.
- R4: When both channels are enabled after a command write, the starts alternate between the channels, and voltage goes first.
- R5: When `adc_done` arrives, `adc_result` is stored as that channel's code and the channel's valid flag goes high.
- R6: A single-shot bit clears when its channel's conversion completes. After that, the channel converts again only if its free-running bit is set.
- R7: `not_ready` is high while either single-shot bit is pending, and low otherwise.
- R8: A command write that enables a channel clears that channel's valid flag and sets its code to zero. A read before the first new result therefore returns zeros.
- R9: `adc_range` carries command bit 4, latched when a conversion starts. `volt_range` takes that latched value when a voltage result is stored.
- R10: Each stored current result produces one `alert_stb` pulse of one cycle. During that pulse, `curr_code` already holds the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bits | input | 5 | Mode bits [3:0] and range bit [4] |
| adc_start | output | 1 | One-cycle conversion start |
| adc_sel | output | 1 | Channel select, 0 voltage, 1 current |
| adc_range | output | 1 | Range select for the front end |
| adc_done | input | 1 | Conversion complete |
| adc_result | input | 12 | Converted code |
| volt_code | output | 12 | Latest voltage code |
| volt_range | output | 1 | Range used for the voltage code |
| volt_valid | output | 1 | Voltage code is fresh |
| curr_code | output | 12 | Latest current code |
| curr_valid | output | 1 | Current code is fresh |
| volt_active | output | 1 | Voltage channel enabled |
| curr_active | output | 1 | Current channel enabled |
| not_ready | output | 1 | A single shot is pending; reads refused |
| alert_stb | output | 1 | New current result strobe |

## Verification
A stuck single-shot bit shows at the ports in two ways. `not_ready` stays high, and one conversion after the expected result there is an extra start on that channel. A corrupted channel-history register shows up on the second start after a command write as two starts on the same channel in a row. A failure to clear the result store on enable shows up on the cycle right after the write, as a nonzero code or a high valid flag. A misrouted capture puts the wrong code on the wrong channel one cycle after `adc_done`.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int CODE_W_DEF = 12;

    typedef enum logic {
        CH_VOLT = 1'b0,
        CH_CURR = 1'b1
    } chan_e;

    // field order matches the command bit positions 4..0
    typedef struct packed {
        logic range_sel;
        logic cur_once;
        logic cur_cont;
        logic volt_once;
        logic volt_cont;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    function automatic chan_e pick_chan(logic v_on, logic c_on, chan_e last);
        if (v_on && c_on)
            return (last == CH_VOLT) ? CH_CURR : CH_VOLT;
        else if (c_on)
            return CH_CURR;
        else
            return CH_VOLT;
    endfunction

endpackage

// File: rtl/conv_seq_mode.sv
module conv_seq_mode
    import conv_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  mode_t wr_mode,
    input  logic  done_evt,
    input  chan_e done_chan,
    output mode_t mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_mode;
        end else if (done_evt) begin
            if (done_chan == CH_VOLT)
                mode_q.volt_once <= 1'b0;
            else
                mode_q.cur_once <= 1'b0;
        end
    end

endmodule

// File: rtl/conv_seq_arb.sv
module conv_seq_arb
    import conv_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  v_on,
    input  logic  c_on,
    input  logic  range_in,
    input  logic  adc_done,
    output logic  adc_start,
    output chan_e adc_sel,
    output logic  adc_range,
    output logic  done_evt,
    output chan_e done_chan
);

    seq_state_e state_q;
    chan_e      last_q;
    chan_e      next_ch;

    assign next_ch   = pick_chan(v_on, c_on, last_q);
    assign done_evt  = (state_q == ST_WAIT) && adc_done;
    assign done_chan = adc_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            last_q    <= CH_CURR;
            adc_start <= 1'b0;
            adc_sel   <= CH_VOLT;
            adc_range <= 1'b0;
        end else begin
            adc_start <= 1'b0;
            if (restart)
                last_q <= CH_CURR;
            case (state_q)
                ST_IDLE: begin
                    if (v_on || c_on) begin
                        adc_start <= 1'b1;
                        adc_sel   <= next_ch;
                        adc_range <= range_in;
                        if (!restart)
                            last_q <= next_ch;
                        state_q   <= ST_WAIT;
                    end
                end
                default: begin
                    if (adc_done)
                        state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/conv_seq_slot.sv
module conv_seq_slot #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] code_q,
    output logic              valid_q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else if (cap) begin
            code_q  <= din;
            valid_q <= 1'b1;
        end
    end

endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [MODE_W-1:0] cmd_bits,
    output logic              adc_start,
    output logic              adc_sel,
    output logic              adc_range,
    input  logic              adc_done,
    input  logic [CODE_W-1:0] adc_result,
    output logic [CODE_W-1:0] volt_code,
    output logic              volt_range,
    output logic              volt_valid,
    output logic [CODE_W-1:0] curr_code,
    output logic              curr_valid,
    output logic              volt_active,
    output logic              curr_active,
    output logic              not_ready,
    output logic              alert_stb
);

    localparam int NCH = 2;

    mode_t mode_q;
    mode_t new_mode;
    chan_e sel_e;
    chan_e done_chan;
    logic  done_evt;
    logic  v_on;
    logic  c_on;

    logic [NCH-1:0]    clr_v;
    logic [NCH-1:0]    cap_v;
    logic [NCH-1:0]    valid_v;
    logic [CODE_W-1:0] code_v [NCH];

    assign new_mode = mode_t'(cmd_bits);
    assign v_on     = mode_q.volt_cont | mode_q.volt_once;
    assign c_on     = mode_q.cur_cont  | mode_q.cur_once;

    assign clr_v[0] = cmd_wr & (new_mode.volt_cont | new_mode.volt_once);
    assign clr_v[1] = cmd_wr & (new_mode.cur_cont  | new_mode.cur_once);

    conv_seq_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cmd_wr),
        .wr_mode   (new_mode),
        .done_evt  (done_evt),
        .done_chan (done_chan),
        .mode_q    (mode_q)
    );

    conv_seq_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .restart   (cmd_wr),
        .v_on      (v_on),
        .c_on      (c_on),
        .range_in  (mode_q.range_sel),
        .adc_done  (adc_done),
        .adc_start (adc_start),
        .adc_sel   (sel_e),
        .adc_range (adc_range),
        .done_evt  (done_evt),
        .done_chan (done_chan)
    );

    assign adc_sel = sel_e;

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        assign cap_v[g] = done_evt && (done_chan == ((g == 0) ? CH_VOLT : CH_CURR));
        conv_seq_slot #(.CODE_W(CODE_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr_v[g]),
            .cap     (cap_v[g]),
            .din     (adc_result),
            .code_q  (code_v[g]),
            .valid_q (valid_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            volt_range <= 1'b0;
            alert_stb  <= 1'b0;
        end else begin
            alert_stb <= cap_v[1] & ~clr_v[1];
            if (clr_v[0])
                volt_range <= 1'b0;
            else if (cap_v[0])
                volt_range <= adc_range;
        end
    end

    assign volt_code   = code_v[0];
    assign curr_code   = code_v[1];
    assign volt_valid  = valid_v[0];
    assign curr_valid  = valid_v[1];
    assign volt_active = v_on;
    assign curr_active = c_on;
    assign not_ready   = mode_q.volt_once | mode_q.cur_once;

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic [4:0] cmd_bits,
    input logic       adc_start,
    input logic       adc_done,
    input logic       not_ready,
    input logic       volt_valid,
    input logic       alert_stb,
    input logic       curr_valid
);

    logic inflight_q;

    always_ff @(posedge clk) begin
        if (rst)
            inflight_q <= 1'b0;
        else if (adc_start)
            inflight_q <= 1'b1;
        else if (adc_done)
            inflight_q <= 1'b0;
    end

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    p_one_inflight_r3: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> !inflight_q);

    p_ready_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(not_ready) |-> ($past(adc_done) || $past(cmd_wr)));

    p_valid_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (cmd_bits[0] || cmd_bits[1])) |=> !volt_valid);

    p_strobe_valid_r10: assert property (@(posedge clk) disable iff (rst)
        alert_stb |-> curr_valid);

endmodule

bind conv_seq conv_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .cmd_bits   (cmd_bits),
    .adc_start  (adc_start),
    .adc_done   (adc_done),
    .not_ready  (not_ready),
    .volt_valid (volt_valid),
    .alert_stb  (alert_stb),
    .curr_valid (curr_valid)
);

// File: tb/conv_seq_bench.sv
module conv_seq_bench;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [4:0]  cmd_bits = '0;
    logic        adc_start, adc_sel, adc_range;
    logic        adc_done = 1'b0;
    logic [11:0] adc_result = '0;
    logic [11:0] volt_code, curr_code;
    logic        volt_range, volt_valid, curr_valid;
    logic        volt_active, curr_active, not_ready, alert_stb;

    int total = 0;
    int bad = 0;

    // ADC model bookkeeping
    int          nstart = 0;
    int          ndone_v = 0;
    int          ndone_c = 0;
    int          nstb = 0;
    int          stb_err = 0;
    int          overlap_err = 0;
    int          width_err = 0;
    logic        sel_log [256];
    logic        rng_last = 1'b0;
    logic [11:0] last_v = '0;
    logic [11:0] last_c = '0;

    always #10 clk = ~clk;

    conv_seq u_conv_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_bits   (cmd_bits),
        .adc_start  (adc_start),
        .adc_sel    (adc_sel),
        .adc_range  (adc_range),
        .adc_done   (adc_done),
        .adc_result (adc_result),
        .volt_code  (volt_code),
        .volt_range (volt_range),
        .volt_valid (volt_valid),
        .curr_code  (curr_code),
        .curr_valid (curr_valid),
        .volt_active(volt_active),
        .curr_active(curr_active),
        .not_ready  (not_ready),
        .alert_stb  (alert_stb)
    );

    // converter model: answers each start after LAT cycles
    initial begin
        int   cnt;
        logic cur_sel;
        logic prev_start;
        cnt = 0;
        cur_sel = 1'b0;
        prev_start = 1'b0;
        forever begin
            @(negedge clk);
            adc_done = 1'b0;
            if (adc_start && prev_start) width_err++;
            prev_start = adc_start;
            if (adc_start) begin
                if (cnt > 0) overlap_err++;
                cur_sel = adc_sel;
                rng_last = adc_range;
                if (nstart < 256) sel_log[nstart] = adc_sel;
                nstart++;
                cnt = LAT;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    adc_done = 1'b1;
                    if (!cur_sel) begin
                        adc_result = 12'h100 + 12'(ndone_v);
                        last_v = adc_result;
                        ndone_v++;
                    end else begin
                        adc_result = 12'h800 + 12'(ndone_c * 3);
                        last_c = adc_result;
                        ndone_c++;
                    end
                end
            end
        end
    end

    // alert strobe monitor (R10)
    initial begin
        forever begin
            @(negedge clk);
            if (alert_stb) begin
                nstb++;
                if (curr_code != last_c) stb_err++;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [4:0] b);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_bits = b;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(volt_code == 0 && curr_code == 0, "R1 codes", {volt_code, curr_code}, 0);
        chk({volt_valid, curr_valid, volt_range, not_ready, volt_active, curr_active, alert_stb} == 0,
            "R1 flags", {volt_valid, curr_valid, volt_range, not_ready, volt_active, curr_active, alert_stb}, 0);
        idle(5);
        chk(nstart == 0, "R1 no start", nstart, 0);
    endtask

    task automatic t_volt_once;
        int s0;
        int k;
        wr_cmd(5'h02);
        chk(volt_active && !curr_active, "R2 active", {volt_active, curr_active}, 2'b10);
        chk(not_ready == 1'b1, "R7 pending", not_ready, 1);
        k = 0;
        while (!volt_valid && k < 50) begin @(negedge clk); k++; end
        chk(volt_valid, "R5 valid", volt_valid, 1);
        chk(volt_code == last_v, "R5 code", volt_code, last_v);
        chk(!not_ready, "R7 released", not_ready, 0);
        chk(!volt_active, "R6 self clear", volt_active, 0);
        s0 = nstart;
        idle(20);
        chk(nstart == s0, "R6 no repeat", nstart, s0);
    endtask

    task automatic t_both_cont;
        int s0, st0, c0, k;
        wr_cmd(5'h05);
        chk(!volt_valid && volt_code == 0, "R8 volt zero", {volt_valid, volt_code}, 0);
        chk(!curr_valid && curr_code == 0, "R8 curr zero", {curr_valid, curr_code}, 0);
        chk(curr_active && volt_active, "R2 both active", {volt_active, curr_active}, 2'b11);
        s0 = nstart; st0 = nstb; c0 = ndone_c;
        k = 0;
        while (nstart < s0 + 6 && k < 200) begin @(negedge clk); k++; end
        for (int i = 0; i < 6; i++)
            chk(sel_log[s0 + i] == 1'(i % 2), "R4 alternation", sel_log[s0 + i], i % 2);
        wr_cmd(5'h00);
        idle(10);
        chk(curr_code == last_c, "R5 curr code", curr_code, last_c);
        chk(nstb - st0 == ndone_c - c0, "R10 strobe count", nstb - st0, ndone_c - c0);
        chk(stb_err == 0, "R10 strobe code", stb_err, 0);
        chk(overlap_err == 0 && width_err == 0, "R3 handshake", {overlap_err[15:0], width_err[15:0]}, 0);
    endtask

    task automatic t_range;
        int k;
        wr_cmd(5'h11);
        k = 0;
        while (!volt_valid && k < 50) begin @(negedge clk); k++; end
        chk(rng_last == 1'b1, "R9 range to adc", rng_last, 1);
        chk(volt_range == 1'b1, "R9 range stored", volt_range, 1);
        wr_cmd(5'h00);
        idle(10);
        wr_cmd(5'h01);
        chk(volt_range == 1'b0 && !volt_valid, "R8 range cleared", {volt_range, volt_valid}, 0);
        k = 0;
        while (!volt_valid && k < 50) begin @(negedge clk); k++; end
        chk(rng_last == 1'b0, "R9 wide range", rng_last, 0);
        chk(volt_range == 1'b0, "R9 stored wide", volt_range, 0);
        wr_cmd(5'h00);
        idle(10);
    endtask

    task automatic t_curr_once_cont;
        int s0, k;
        logic any_v;
        s0 = nstart;
        wr_cmd(5'h0C);
        chk(not_ready && curr_active && !volt_active, "R7 curr pending", {not_ready, curr_active, volt_active}, 3'b110);
        k = 0;
        while (!curr_valid && k < 50) begin @(negedge clk); k++; end
        chk(!not_ready, "R6 once cleared", not_ready, 0);
        chk(curr_active, "R6 cont kept", curr_active, 1);
        chk(curr_code == last_c, "R5 curr result", curr_code, last_c);
        idle(12);
        any_v = 1'b0;
        for (int i = s0; i < nstart && i < 256; i++) any_v |= ~sel_log[i];
        chk(!any_v && nstart > s0 + 1, "R3 current only", any_v, 0);
        wr_cmd(5'h00);
        idle(10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_volt_once();
        t_both_cont();
        t_range();
        t_curr_once_cont();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule